// File: doc/BRIEF.md
# Sixteen-Pin Memory-Mapped GPIO Port

This block is one 16-pin general-purpose I/O port with a 32-bit register interface. Software gives each pin one of four modes: input, output, alternate function or analog. It also sets each pin's output type, pull resistor, drive-speed code and alternate-source selection. Software reads the pad levels through a two-flop synchronizer. It drives the outputs in one of two ways: through an output-data register that reads back, or through a write-only register that sets and clears single bits in one write.

The pad side has one level per pin coming in. Going out, each pin has a driven value, an output-enable, an open-drain flag, pull-up and pull-down requests and an input-buffer enable. In alternate-function mode a pin takes its value from 1 of 15 peripheral sources. Selection 0 keeps the pin driven from the output-data register.

The bus interface is simple. A write takes effect on the rising clock edge while the write strobe is high. Read data is combinational and is 0 whenever the read strobe is low.

Top module: `gpio_port16`

## Requirements
- R1: After reset, every register reads 0 and every pin is an input. pad_oe, pad_out, pad_pu and pad_pd are all 0, and pad_ie is all 1.
- R2: These offsets read back the last value written: mode 0x00, output type 0x04 (bits [15:0] only; upper bits read 0), speed 0x08, pull 0x0C, output data 0x14 (bits [15:0] only), alternate low 0x20 and alternate high 0x24.
- R3: The input register at 0x10 returns a new pad level at the second rising edge after that level is applied. Pins in analog mode read 0. Writes to 0x10 have no effect.
- R4: A write to 0x18 sets output-data bit n when wdata[n] is 1 and clears it when wdata[16+n] is 1. A 0 leaves the bit unchanged. When both bits are 1, the output bit becomes 1. A read of 0x18 returns 0.
- R5: A pin whose mode field (bits [2n+1:2n]) is 01 drives its output-data bit with pad_oe high when its output-type bit is 0.
- R6: When output-type bit n is 1 (open-drain), pad_od[n] is 1 and a driven pin has pad_oe[n] high only while its driven value is 0.
- R7: In mode 10, pin n takes the selection sel from the alternate registers. Pins 0–7 use the low register at bits [4n+3:4n]. Pins 8–15 use the high register at bits [4(n-8)+3:4(n-8)]. sel 0 drives the output-data bit. sel s from 1 to 15 drives alt_src[15n+s-1].
- R8: The pull field (bits [2n+1:2n] of 0x0C) requests a pull-up with 01 and a pull-down with 10. It requests neither with 00 or 11.
- R9: In mode 11 (analog), the pin has pad_oe, pad_pu, pad_pd and pad_ie all at 0.
- R10: In mode 00 (input), pad_oe of the pin is 0.
- R11: Reads of 0x1C, of any offset above 0x24 and of any address not a multiple of 4 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, 0 when bus_re is low |
| pad_in | input | 16 | Pad levels |
| alt_src | input | 240 | 15 alternate sources per pin, pin n at [15n+14:15n] |
| pad_out | output | 16 | Driven value per pin |
| pad_oe | output | 16 | Output-enable per pin |
| pad_od | output | 16 | Open-drain flag per pin |
| pad_pu | output | 16 | Pull-up request per pin |
| pad_pd | output | 16 | Pull-down request per pin |
| pad_ie | output | 16 | Input-buffer enable per pin |

## Verification
The bench reads the input register one edge and two edges after a pad change. A design with one flop too few or too many returns the new value in the wrong read. The set/reset tests include a pin whose set and clear bits are both 1, so a design that lets the clear win drives that pin low. They also include zero bits that must leave the output data alone. In the alternate-function tests, one pin uses the low register and one uses the high register, at selections 5 and 15, with the other sources set to the opposite level. A wrong bit-slice or an off-by-one source index therefore shows up on pad_out. The open-drain, pull and analog tests check that a released open-drain 1, a pull field of 11 and an analog pin all leave the matching pad controls low.

// File: rtl/gpio_port16.sv
module gpio_port16 #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic [15:0]       pad_in,
  input  logic [239:0]      alt_src,
  output logic [15:0]       pad_out,
  output logic [15:0]       pad_oe,
  output logic [15:0]       pad_od,
  output logic [15:0]       pad_pu,
  output logic [15:0]       pad_pd,
  output logic [15:0]       pad_ie
);
  localparam int NPIN = 16;
  localparam int NSRC = 15;
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_TYPE = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_SPD  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_PULL = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_SR   = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_AFL  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_AFH  = ADDR_W'('h24);

  logic [31:0]     mode_q, spd_q, pull_q, afl_q, afh_q;
  logic [NPIN-1:0] type_q, odat_q, sync1_q, sync2_q, analog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; spd_q <= '0; pull_q <= '0; afl_q <= '0; afh_q <= '0;
      type_q <= '0; odat_q <= '0; sync1_q <= '0; sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (bus_we) begin
        case (bus_addr)
          A_MODE: mode_q <= bus_wdata;
          A_TYPE: type_q <= bus_wdata[NPIN-1:0];
          A_SPD:  spd_q  <= bus_wdata;
          A_PULL: pull_q <= bus_wdata;
          A_OUT:  odat_q <= bus_wdata[NPIN-1:0];
          A_SR:   odat_q <= (odat_q & ~bus_wdata[31:16]) | bus_wdata[15:0];
          A_AFL:  afl_q  <= bus_wdata;
          A_AFH:  afh_q  <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_addr)
        A_MODE: bus_rdata = mode_q;
        A_TYPE: bus_rdata = {16'h0, type_q};
        A_SPD:  bus_rdata = spd_q;
        A_PULL: bus_rdata = pull_q;
        A_IN:   bus_rdata = {16'h0, sync2_q & ~analog};
        A_OUT:  bus_rdata = {16'h0, odat_q};
        A_AFL:  bus_rdata = afl_q;
        A_AFH:  bus_rdata = afh_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    logic [1:0]      md, pl;
    logic [3:0]      sel;
    logic [NSRC:0]   cand;
    logic            drv, val;
    assign md   = mode_q[2*n+1:2*n];
    assign pl   = pull_q[2*n+1:2*n];
    if (n < 8) begin : g_lo
      assign sel = afl_q[4*n +: 4];
    end else begin : g_hi
      assign sel = afh_q[4*(n-8) +: 4];
    end
    assign cand = {alt_src[NSRC*n +: NSRC], odat_q[n]};
    assign drv  = (md == 2'b01) || (md == 2'b10);
    assign val  = (md == 2'b10) ? cand[sel] : odat_q[n];
    assign analog[n] = (md == 2'b11);
    assign pad_out[n] = drv & val;
    assign pad_oe[n]  = drv & (~type_q[n] | ~val);
    assign pad_od[n]  = type_q[n];
    assign pad_pu[n]  = ~analog[n] & (pl == 2'b01);
    assign pad_pd[n]  = ~analog[n] & (pl == 2'b10);
    assign pad_ie[n]  = ~analog[n];
  end
endmodule

module gpio_port16_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_re,
  input logic [31:0]       bus_rdata,
  input logic [15:0]       pad_out,
  input logic [15:0]       pad_oe,
  input logic [15:0]       pad_od,
  input logic [15:0]       pad_pu,
  input logic [15:0]       pad_pd,
  input logic [15:0]       pad_ie
);
  logic mapped;
  assign mapped = (bus_addr == ADDR_W'('h00)) || (bus_addr == ADDR_W'('h04)) ||
                  (bus_addr == ADDR_W'('h08)) || (bus_addr == ADDR_W'('h0C)) ||
                  (bus_addr == ADDR_W'('h10)) || (bus_addr == ADDR_W'('h14)) ||
                  (bus_addr == ADDR_W'('h20)) || (bus_addr == ADDR_W'('h24));

  assert_sr_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == ADDR_W'('h18)) |-> (bus_rdata == 32'h0));

  assert_od_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & pad_od & pad_out) == 16'h0));

  assert_analog_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pad_ie & (pad_oe | pad_pu | pad_pd)) == 16'h0));

  assert_analog_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == ADDR_W'('h10)) |-> ((bus_rdata[15:0] & ~pad_ie) == 16'h0));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !mapped) |-> (bus_rdata == 32'h0));

  assert_single_pull_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_pd) == 16'h0));

  assert_idle_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> (bus_rdata == 32'h0));
endmodule

bind gpio_port16 gpio_port16_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_re(bus_re),
  .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
  .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_ie(pad_ie)
);

// File: tb/gpio_port16_tb_top.sv
`timescale 1ns/1ps
module gpio_port16_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic         bus_we = 1'b0;
  logic         bus_re = 1'b0;
  logic [31:0]  bus_rdata;
  logic [15:0]  pad_in = '0;
  logic [239:0] alt_src = '0;
  logic [15:0]  pad_out, pad_oe, pad_od, pad_pu, pad_pd, pad_ie;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port16 #(.ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .alt_src(alt_src), .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_ie(pad_ie)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check("R1 oe", {16'h0, pad_oe}, 32'h0);
    check("R1 out", {16'h0, pad_out}, 32'h0);
    check("R1 ie", {16'h0, pad_ie}, 32'h0000FFFF);
    check("R1 pull", {pad_pu, pad_pd}, 32'h0);
    rd(8'h00, r); check("R1 mode", r, 32'h0);
    rd(8'h14, r); check("R1 odat", r, 32'h0);
    rd(8'h24, r); check("R1 afh", r, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] r;
    wr(8'h08, 32'hA5A5_1234); rd(8'h08, r); check("R2 speed", r, 32'hA5A5_1234);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, r); check("R2 type", r, 32'h0000_FFFF);
    wr(8'h14, 32'h1234_ABCD); rd(8'h14, r); check("R2 odat", r, 32'h0000_ABCD);
    wr(8'h20, 32'h1357_9BDF); rd(8'h20, r); check("R2 afl", r, 32'h1357_9BDF);
    wr(8'h24, 32'h0246_8ACE); rd(8'h24, r); check("R2 afh", r, 32'h0246_8ACE);
    wr(8'h0C, 32'h3C3C_0F0F); rd(8'h0C, r); check("R2 pull", r, 32'h3C3C_0F0F);
    wr(8'h00, 32'h0000_0000); rd(8'h00, r); check("R2 mode", r, 32'h0);
    check("R10 input no oe", {16'h0, pad_oe}, 32'h0);
    wr(8'h04, 32'h0); wr(8'h14, 32'h0); wr(8'h20, 32'h0);
    wr(8'h24, 32'h0); wr(8'h0C, 32'h0);
  endtask

  task automatic t_input();
    logic [31:0] r;
    @(negedge clk); pad_in = 16'h5A5A;
    rd(8'h10, r); check("R3 one edge old", r, 32'h0);
    rd(8'h10, r); check("R3 two edges new", r, 32'h0000_5A5A);
    wr(8'h10, 32'h0000_FFFF); rd(8'h10, r); check("R3 write ignored", r, 32'h0000_5A5A);
    wr(8'h00, 32'h0000_000C); rd(8'h10, r); check("R3 analog masked", r, 32'h0000_5A58);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_setreset();
    logic [31:0] r;
    wr(8'h00, 32'h5555_5555);
    wr(8'h14, 32'h0000_00F0);
    wr(8'h18, 32'h0030_0001); rd(8'h14, r); check("R4 set/clear", r, 32'h0000_00C1);
    wr(8'h18, 32'h0100_0100); rd(8'h14, r); check("R4 set wins", r, 32'h0000_01C1);
    wr(8'h18, 32'h0000_0000); rd(8'h14, r); check("R4 zero no change", r, 32'h0000_01C1);
    rd(8'h18, r); check("R4 read zero", r, 32'h0);
    check("R5 out", {16'h0, pad_out}, 32'h0000_01C1);
    check("R5 oe", {16'h0, pad_oe}, 32'h0000_FFFF);
  endtask

  task automatic t_opendrain();
    wr(8'h04, 32'h0000_0001);
    check("R6 od flag", {16'h0, pad_od}, 32'h0000_0001);
    check("R6 released 1", {16'h0, pad_oe}, 32'h0000_FFFE);
    wr(8'h18, 32'h0001_0000);
    check("R6 driven 0 oe", {16'h0, pad_oe}, 32'h0000_FFFF);
    check("R6 driven 0 out", {16'h0, pad_out}, 32'h0000_01C0);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_altfunc();
    wr(8'h00, 32'hAAAA_AAAA);
    check("R7 sel0 gpio", {16'h0, pad_out}, 32'h0000_01C0);
    wr(8'h20, 32'h0000_5000);
    wr(8'h24, 32'h000F_0000);
    @(negedge clk);
    alt_src = '0; alt_src[49] = 1'b1; alt_src[194] = 1'b1;
    #1 check("R7 sources high", {16'h0, pad_out}, 32'h0000_11C8);
    @(negedge clk);
    alt_src = '1; alt_src[49] = 1'b0;
    #1 check("R7 sources low", {16'h0, pad_out}, 32'h0000_11C0);
    check("R7 oe", {16'h0, pad_oe}, 32'h0000_FFFF);
    wr(8'h20, 32'h0); wr(8'h24, 32'h0);
  endtask

  task automatic t_pull_analog();
    wr(8'h0C, 32'h0000_00E4);
    check("R8 pull-up", {16'h0, pad_pu}, 32'h0000_0002);
    check("R8 pull-down", {16'h0, pad_pd}, 32'h0000_0004);
    wr(8'h00, 32'h0000_000C);
    check("R9 analog pu", {16'h0, pad_pu}, 32'h0);
    check("R9 analog pd", {16'h0, pad_pd}, 32'h0000_0004);
    check("R9 analog ie", {16'h0, pad_ie}, 32'h0000_FFFD);
    check("R10 input oe", {16'h0, pad_oe}, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] r;
    rd(8'h1C, r); check("R11 lock", r, 32'h0);
    rd(8'h28, r); check("R11 above", r, 32'h0);
    rd(8'hFC, r); check("R11 top", r, 32'h0);
    rd(8'h01, r); check("R11 misaligned", r, 32'h0);
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h00, r); check("R11 write no effect", r, 32'h0000_000C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_input();
    t_setreset();
    t_opendrain();
    t_altfunc();
    t_pull_analog();
    t_unmapped();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule